// File: doc/BRIEF.md
# Ring Oscillator Frequency Monitor

The block estimates on-chip process, voltage and temperature conditions by measuring how fast a set of ring oscillators runs. Each channel selects one of its sub-rings, opens a counting window of a programmable number of reference-clock cycles, and counts the rising edges of the selected ring during that window. With a 24 MHz reference, a window of N microseconds is programmed as N*24 cycles.

The ring edge count is kept in the oscillator's own clock domain. A level gate travels from the reference domain to the ring domain through a synchroniser, and an acknowledge travels back the same way. The reference side copies the count only after the acknowledge shows that the ring side has stopped counting. Only then does it raise the channel's done flag.

Software drives the block through a small word-addressed register file. The control word takes write-enable bits in its upper half. Separate words hold each channel's window length, the done flags and each channel's captured count.

Top module: `rofm_top`

## Requirements
- R1: A write to the control word (address 0) changes data bit i (i in 0..15) only when write bit 16+i is 1. Bits with a 0 enable keep their value. A read of address 0 returns the control bits in 15:0 and zero above.
- R2: Channel c has its start bit at 8c and its enable bit at 8c+1. Its ring-select field is SEL_W bits wide, starts at bit 4c+2, and selects ring input c*NSUB+sel.
- R3: Address 1+c holds channel c's window length in reference cycles. Bit c of address 3 is channel c's done flag. Address 4+c holds channel c's captured count.
- R4: A 0-to-1 transition of start on an enabled channel begins a measurement. After the window, done is set and the count equals the number of selected-ring rising edges in a window of that many reference cycles, within two edges.
- R5: While done stays set, the captured count does not change.
- R6: Clearing start clears done within two reference cycles, and it abandons a measurement in progress without setting done. A start sequence 1-0-1 yields a fresh measurement that begins from zero.
- R7: While enable is 0, the channel is idle, its done flag is 0 and its count reads 0.
- R8: A start bit set while enable is 0 never produces a done flag.
- R9: A start given while the window length is 0 sets done on the second reference edge after the control write, and the count is 0.
- R10: The ring-side count saturates at 2^CNT_W-1 instead of wrapping.
- R11: After reset, every readable word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_clk_i | input | NCH*NSUB | Ring oscillator clocks, channel-major |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address |
| wr_data_i | input | 32 | Write data; for control, upper half is write enables |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data, combinational |

## Verification
The assertions check the following on every cycle:
- Masked bits of the control word hold their value, and the control word changes only on a write to its address.
- A channel with enable or start low has no done flag on the next cycle.
- The captured count holds still while done stays set.
- A zero-length window completes on the next cycle with a zero count.
- The gate never rises while the previous ring-side window is still acknowledged.
- The ring-side counter neither wraps nor leaves its maximum once it is there.

Some behaviour only the bench's scenarios can show:
- That the captured count matches the ring-to-reference frequency ratio for different rings and windows.
- That the select field routes the intended ring.
- That an aborted window never reports.
- That a fast 1-0-1 restart produces a clean count.

// File: rtl/rofm_pkg.sv
`timescale 1ns/1ps
package rofm_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int A_CTRL  = 0;
  localparam int A_CAL0  = 1;
  localparam int A_STAT  = 3;
  localparam int A_FREQ0 = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} ch_state_e;

  function automatic int start_pos(int ch);
    return ch * 8;
  endfunction
  function automatic int en_pos(int ch);
    return ch * 8 + 1;
  endfunction
  function automatic int sel_pos(int ch);
    return ch * 4 + 2;
  endfunction
endpackage

// File: rtl/rofm_sync.sv
`timescale 1ns/1ps
module rofm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end
  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rofm_ring_cnt.sv
`timescale 1ns/1ps
module rofm_ring_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             ring_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic gate_s, gate_d;
  logic [CNT_W-1:0] cnt_q;

  rofm_sync #(.STAGES(2)) u_gate_sync (
    .clk_i(ring_clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s)
  );

  // first edge of a new window clears, later edges count
  always_ff @(posedge ring_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d)                cnt_q <= '0;
      else if (gate_s && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ack_o = gate_d;
  assign cnt_o = cnt_q;

  // R10
  sat_hold_chk: assert property (@(posedge ring_clk_i) disable iff (!rst_ni)
    (gate_s && gate_d && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R10
  no_wrap_chk: assert property (@(posedge ring_clk_i) disable iff (!rst_ni)
    (gate_s && gate_d) |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/rofm_chan.sv
`timescale 1ns/1ps
module rofm_chan
  import rofm_pkg::*;
#(
  parameter int unsigned NSUB  = 4,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CAL_W = 20,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSUB-1:0]  ring_clk_i,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CAL_W-1:0] cal_i,
  output logic             done_o,
  output logic [CNT_W-1:0] freq_o
);
  ch_state_e        state_q;
  logic             gate_q, ack_r, ack_s;
  logic [CAL_W-1:0] win_q;
  logic [CNT_W-1:0] freq_q, ring_cnt;
  logic             ring_clk;

  // behavioural ring mux; select must be stable across a window
  assign ring_clk = ring_clk_i[sel_i];

  rofm_ring_cnt #(.CNT_W(CNT_W)) u_ring (
    .ring_clk_i(ring_clk), .rst_ni(rst_ni), .gate_i(gate_q),
    .ack_o(ack_r), .cnt_o(ring_cnt)
  );

  rofm_sync #(.STAGES(2)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_r), .q_o(ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
      win_q   <= '0;
      freq_q  <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
      win_q   <= '0;
      freq_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (cal_i == '0) begin
              freq_q  <= '0;
              state_q <= ST_DONE;
            end else if (!ack_s) begin
              gate_q  <= 1'b1;
              win_q   <= cal_i;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (!start_i) begin
            gate_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            if (win_q > 1) win_q <= win_q - 1'b1;
            // hold the gate until the ring side has seen it
            if (win_q <= 1 && ack_s) begin
              gate_q  <= 1'b0;
              state_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (!start_i) state_q <= ST_IDLE;
          else if (!ack_s) begin
            freq_q  <= ring_cnt;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: if (!start_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign freq_o = freq_q;

  // R7
  en_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!done_o && freq_o == '0));
  // R6
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  // R5
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && en_i && start_i) |=> (!done_o || $stable(freq_o)));
  // R9
  cal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && state_q == ST_IDLE && cal_i == '0) |=> (done_o && freq_o == '0));
  // R6
  clean_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> !$past(ack_s));
endmodule

// File: rtl/rofm_top.sv
`timescale 1ns/1ps
module rofm_top
  import rofm_pkg::*;
#(
  parameter int unsigned NCH   = 2,
  parameter int unsigned NSUB  = 4,
  parameter int unsigned CAL_W = 20,
  parameter int unsigned CNT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH*NSUB-1:0]    ring_clk_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [31:0]            wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [31:0]            rd_data_o
);
  localparam int unsigned SEL_W = (NSUB > 1) ? $clog2(NSUB) : 1;

  logic [15:0]      ctrl_q;
  logic [CAL_W-1:0] cal_q  [NCH];
  logic [NCH-1:0]   done;
  logic [CNT_W-1:0] freq   [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      for (int c = 0; c < NCH; c++) cal_q[c] <= '0;
    end else if (wr_en_i) begin
      if (int'(wr_addr_i) == A_CTRL)
        ctrl_q <= (ctrl_q & ~wr_data_i[31:16]) | (wr_data_i[15:0] & wr_data_i[31:16]);
      for (int c = 0; c < NCH; c++)
        if (int'(wr_addr_i) == A_CAL0 + c) cal_q[c] <= wr_data_i[CAL_W-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int STB = start_pos(g);
    localparam int ENB = en_pos(g);
    localparam int SLB = sel_pos(g);
    rofm_chan #(.NSUB(NSUB), .SEL_W(SEL_W), .CAL_W(CAL_W), .CNT_W(CNT_W)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ring_clk_i(ring_clk_i[g*NSUB +: NSUB]),
      .en_i(ctrl_q[ENB]), .start_i(ctrl_q[STB]),
      .sel_i(ctrl_q[SLB +: SEL_W]), .cal_i(cal_q[g]),
      .done_o(done[g]), .freq_o(freq[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) == A_CTRL) rd_data_o = {16'h0, ctrl_q};
    if (int'(rd_addr_i) == A_STAT) rd_data_o = 32'(done);
    for (int c = 0; c < NCH; c++) begin
      if (int'(rd_addr_i) == A_CAL0 + c)  rd_data_o = 32'(cal_q[c]);
      if (int'(rd_addr_i) == A_FREQ0 + c) rd_data_o = 32'(freq[c]);
    end
  end

  // R1
  ctrl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_addr_i) == A_CTRL) |=>
      (((ctrl_q ^ $past(ctrl_q)) & ~$past(wr_data_i[31:16])) == 16'h0));
  // R1
  ctrl_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && int'(wr_addr_i) == A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_rofm_top.sv
`timescale 1ns/1ps
module sim_rofm_top;
  localparam int NCH = 2, NSUB = 4, CAL_W = 20, CNT_W = 8;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH*NSUB-1:0] ring;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;

  int n_chk = 0, n_bad = 0;
  bit  finished = 0;

  function automatic int per_ps(int idx);
    case (idx)
      0: return 3000;  1: return 5000;  2: return 7000;  3: return 9000;
      4: return 2000;  5: return 6000;  6: return 10000; default: return 11000;
    endcase
  endfunction

  always #2 clk = ~clk;

  for (genvar g = 0; g < NCH*NSUB; g++) begin : g_ring
    logic r = 1'b0;
    always #(per_ps(g) / 2000.0) r = ~r;
    assign ring[g] = r;
  end

  rofm_top #(.NCH(NCH), .NSUB(NSUB), .CAL_W(CAL_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ring_clk_i(ring),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic int exp_cnt(int idx, int cal);
    int v;
    v = (cal * 4000) / per_ps(idx);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = a[2:0];
    #0.1;
    d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] st_b(int c); return 16'(1 << (8*c)); endfunction
  function automatic logic [15:0] en_b(int c); return 16'(1 << (8*c+1)); endfunction
  function automatic logic [15:0] sel_m(int c); return 16'(3 << (4*c+2)); endfunction
  function automatic logic [15:0] sel_v(int c, int s); return 16'(s << (4*c+2)); endfunction

  // enable + select, then start; poll done; return count
  task automatic measure(input int c, input int s, input int cal, input bit quick_restart,
                         output bit got_done, output int cnt);
    logic [31:0] v;
    wr(1 + c, 32'(cal));
    wr(0, {en_b(c) | sel_m(c), en_b(c) | sel_v(c, s)});
    wr(0, {st_b(c), st_b(c)});
    if (quick_restart) begin
      wr(0, {st_b(c), 16'h0});
      wr(0, {st_b(c), st_b(c)});
    end
    got_done = 0;
    for (int i = 0; i < 4000 && !got_done; i++) begin
      @(negedge clk);
      rd(3, v);
      got_done = v[c];
    end
    rd(4 + c, v);
    cnt = int'(v);
  endtask

  task automatic stop_ch(input int c);
    logic [31:0] v;
    wr(0, {st_b(c), 16'h0});
    @(negedge clk);
    rd(3, v);
    // R6 done drops after start is cleared
    chk(v[c] == 1'b0, "R6", v[c], 0);
  endtask

  task automatic run_meas(input int c, input int s, input int cal, input bit qr, input string req);
    bit d; int got, e, got2; logic [31:0] v;
    measure(c, s, cal, qr, d, got);
    e = exp_cnt(c*NSUB + s, cal);
    chk(d, req, d, 1);
    if (e == CMAX) chk(got == CMAX, "R10", got, e);
    else           chk(got >= e - 2 && got <= e + 2, req, got, e);
    wait_cyc(5);
    rd(4 + c, v); got2 = int'(v);
    // R5 count stable while done
    chk(got2 == got, "R5", got2, got);
    stop_ch(c);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    logic [31:0] v;
    bit d; int got;
    void'($urandom(32'd4242));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R11 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk(v == 0, "R11", v, 0);
    end

    // R1 mask behaviour
    wr(0, {16'h0000, 16'hFFFF});
    rd(0, v); chk(v == 0, "R1", v, 0);
    wr(0, {16'h0004, 16'h00CC});
    rd(0, v); chk(v == 32'h4, "R1", v, 4);
    wr(0, {16'hFFFF, 16'h0000});
    rd(0, v); chk(v == 0, "R1", v, 0);

    // R3 calibration word readback
    wr(2, 32'd777);
    rd(2, v); chk(v == 777, "R3", v, 777);

    // R9 zero window
    wr(1, 32'd0);
    wr(0, {en_b(0) | st_b(0), en_b(0) | st_b(0)});
    @(negedge clk);
    rd(3, v); chk(v[0] == 1'b1, "R9", v[0], 1);
    rd(4, v); chk(v == 0, "R9", v, 0);
    stop_ch(0);

    // R2/R4 directed on each ring
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < NSUB; s++)
        run_meas(c, s, 40, 1'b0, "R4");

    // R10 saturation: 2 ns ring over 200 cycles = 400 edges
    run_meas(1, 0, 200, 1'b0, "R10");

    // R6 quick 1-0-1 restart
    run_meas(1, 1, 36, 1'b1, "R6");

    // R6 abort mid-window
    wr(2, 32'd500);
    wr(0, {en_b(1) | sel_m(1), en_b(1) | sel_v(1, 2)});
    wr(0, {st_b(1), st_b(1)});
    wait_cyc(60);
    wr(0, {st_b(1), 16'h0});
    wait_cyc(600);
    rd(3, v); chk(v[1] == 1'b0, "R6", v[1], 0);

    // R7 enable clear idles a done channel
    measure(0, 1, 30, 1'b0, d, got);
    chk(d, "R4", d, 1);
    wr(0, {en_b(0), 16'h0});
    @(negedge clk);
    rd(3, v); chk(v[0] == 1'b0, "R7", v[0], 0);
    rd(4, v); chk(v == 0, "R7", v, 0);

    // R8 start with enable low: start is still 1 here
    wait_cyc(300);
    rd(3, v); chk(v[0] == 1'b0, "R8", v[0], 0);
    wr(0, {st_b(0), 16'h0});

    // random mix
    for (int i = 0; i < 24; i++) begin
      int c, s, cal;
      c   = $urandom_range(NCH - 1, 0);
      s   = $urandom_range(NSUB - 1, 0);
      cal = $urandom_range(60, 16);
      run_meas(c, s, cal, ($urandom_range(3, 0) == 0), "R4");
    end

    report();
  end
endmodule